// File: doc/BRIEF.md
# Multi-frame HDLC byte FIFO

This block is the byte store for one channel of a basic-rate line controller. It sits between a framer, which writes decoded frame bytes, and software or a DMA engine, which drains them. Each write carries a byte and a flag that marks the last byte of a frame. The flag is stored beside the byte, so the read side can mark the same byte as the end of its frame when it comes out.

Four free-running counters keep track of the traffic, and all four are visible at the ports. Two of them count bytes, one on the write side and one on the read side. The other two count completed frames, one on each side. The byte fill and the frame fill are the wrapped differences of these counters. A threshold monitor can use the byte fill directly. The frame store holds at most seven complete frames. A write that would open an eighth frame is refused, and a sticky overflow flag is set.

Top module: `hdlc_frame_fifo`

## Requirements
- R1: After a synchronous reset, all four counters are zero, `ovf_flag` is low and `rd_valid` is low.
- R2: An accepted write stores the byte together with its end marker and advances `in_byte_cnt` by one, modulo 256. If `wr_eof` is high, it also advances `in_frame_cnt` by one, modulo 8.
- R3: When `fill_bytes` is 255, a write is refused. The byte counters and frame counters do not change, and `ovf_flag` is set.
- R4: A frame-opening write is the first accepted write after reset, or the first accepted write after a byte with the end marker. Such a write is refused when `fill_frames` is 7, and `ovf_flag` is set. Once a frame has been read out, a new frame is accepted again.
- R5: `ovf_flag` stays high from the cycle after any refused write until the next reset.
- R6: A read while `fill_bytes` is not zero advances `out_byte_cnt` by one. In the next cycle `rd_valid` is high, `rd_data` shows the oldest byte in write order, and `rd_eof` shows that byte's end marker.
- R7: A read while `fill_bytes` is zero is ignored. `rd_valid` is low in the next cycle and `out_byte_cnt` does not change.
- R8: `out_frame_cnt` advances by one, modulo 8, on the clock edge that follows a cycle in which `rd_valid` and `rd_eof` are both high.
- R9: `fill_bytes` equals `in_byte_cnt - out_byte_cnt` modulo 256. `fill_frames` equals `in_frame_cnt - out_frame_cnt` modulo 8.
- R10: A write and a read in the same cycle both take effect. The full test for the write uses the fill level before that cycle, so a write is refused at 255 bytes even while a read is also taking place.
- R11: Bytes of a frame that is still open can be read before the frame's end marker has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to store |
| wr_eof | input | 1 | Marks the byte being written as the last byte of its frame |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | `rd_data` and `rd_eof` hold a byte delivered by the previous read |
| rd_data | output | 8 | Delivered byte |
| rd_eof | output | 1 | The delivered byte ends its frame |
| in_byte_cnt | output | 8 | Write-side byte counter |
| out_byte_cnt | output | 8 | Read-side byte counter |
| in_frame_cnt | output | 3 | Write-side completed-frame counter |
| out_frame_cnt | output | 3 | Read-side completed-frame counter |
| fill_bytes | output | 8 | Bytes currently stored |
| fill_frames | output | 3 | Complete frames currently stored |
| ovf_flag | output | 1 | Sticky flag for a refused write |

## Verification
Two operations can fall in the same cycle: the write of a frame's closing byte, and the read of another frame's closing byte. This is provoked by writing one frame completely, then writing the next frame while reading the first, timed so that both closing bytes fall in the same clock. The bench then checks that both frame counters move, each at its own edge, and that the frame fill stays correct. A second case of the same kind is a write and a read issued together at 255 stored bytes. Here the bench expects the write to be refused and the read to complete. A bench-side model recomputes every counter, every fill level and every delivered byte, and compares them after each cycle.

// File: rtl/hdlc_fifo_pkg.sv
package hdlc_fifo_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_ADDR_W = 8;
  localparam int DEF_FRM_W  = 3;
endpackage

// File: rtl/hdlc_fifo_ram.sv
module hdlc_fifo_ram #(
  parameter int W  = 9,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hdlc_fifo_wr_ctl.sv
module hdlc_fifo_wr_ctl #(
  parameter int AW = 8,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_eof,
  input  logic [AW-1:0] out_byte_cnt,
  input  logic [FW-1:0] out_frame_cnt,
  output logic [AW-1:0] in_byte_cnt,
  output logic [FW-1:0] in_frame_cnt,
  output logic          wr_go,
  output logic          frame_open,
  output logic          ovf
);
  localparam logic [AW-1:0] BYTE_CAP = {AW{1'b1}};
  localparam logic [FW-1:0] FRM_CAP  = {FW{1'b1}};

  logic [AW-1:0] fill_b;
  logic [FW-1:0] fill_f;
  logic          room_b;
  logic          room_f;

  assign fill_b = in_byte_cnt - out_byte_cnt;
  assign fill_f = in_frame_cnt - out_frame_cnt;
  assign room_b = (fill_b != BYTE_CAP);
  // continuation bytes of an open frame never hit the frame cap
  assign room_f = frame_open | (fill_f != FRM_CAP);
  assign wr_go  = wr_en & room_b & room_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_byte_cnt  <= '0;
      in_frame_cnt <= '0;
      frame_open   <= 1'b0;
      ovf          <= 1'b0;
    end else begin
      if (wr_go) begin
        in_byte_cnt <= in_byte_cnt + 1'b1;
        frame_open  <= ~wr_eof;
        if (wr_eof) in_frame_cnt <= in_frame_cnt + 1'b1;
      end
      if (wr_en && !wr_go) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_fifo_rd_ctl.sv
module hdlc_fifo_rd_ctl #(
  parameter int AW = 8,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] in_byte_cnt,
  input  logic          q_eof,
  output logic          rd_go,
  output logic [AW-1:0] out_byte_cnt,
  output logic [FW-1:0] out_frame_cnt,
  output logic          rd_valid
);
  assign rd_go = rd_en & (in_byte_cnt != out_byte_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte_cnt  <= '0;
      out_frame_cnt <= '0;
      rd_valid      <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) out_byte_cnt <= out_byte_cnt + 1'b1;
      // the end marker arrives with the registered RAM output
      if (rd_valid && q_eof) out_frame_cnt <= out_frame_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_frame_fifo.sv
module hdlc_frame_fifo
  import hdlc_fifo_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int FRM_W  = DEF_FRM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eof,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eof,
  output logic [ADDR_W-1:0] in_byte_cnt,
  output logic [ADDR_W-1:0] out_byte_cnt,
  output logic [FRM_W-1:0]  in_frame_cnt,
  output logic [FRM_W-1:0]  out_frame_cnt,
  output logic [ADDR_W-1:0] fill_bytes,
  output logic [FRM_W-1:0]  fill_frames,
  output logic              ovf_flag
);
  localparam int ENT_W = DATA_W + 1;

  logic             wr_go;
  logic             rd_go;
  logic             frame_open;
  logic [ENT_W-1:0] q_ent;

  hdlc_fifo_wr_ctl #(.AW(ADDR_W), .FW(FRM_W)) u_wr (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_eof        (wr_eof),
    .out_byte_cnt  (out_byte_cnt),
    .out_frame_cnt (out_frame_cnt),
    .in_byte_cnt   (in_byte_cnt),
    .in_frame_cnt  (in_frame_cnt),
    .wr_go         (wr_go),
    .frame_open    (frame_open),
    .ovf           (ovf_flag)
  );

  hdlc_fifo_rd_ctl #(.AW(ADDR_W), .FW(FRM_W)) u_rd (
    .clk           (clk),
    .rst           (rst),
    .rd_en         (rd_en),
    .in_byte_cnt   (in_byte_cnt),
    .q_eof         (q_ent[DATA_W]),
    .rd_go         (rd_go),
    .out_byte_cnt  (out_byte_cnt),
    .out_frame_cnt (out_frame_cnt),
    .rd_valid      (rd_valid)
  );

  hdlc_fifo_ram #(.W(ENT_W), .AW(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_go),
    .waddr (in_byte_cnt),
    .wdata ({wr_eof, wr_data}),
    .re    (rd_go),
    .raddr (out_byte_cnt),
    .rdata (q_ent)
  );

  assign rd_data     = q_ent[DATA_W-1:0];
  assign rd_eof      = q_ent[DATA_W];
  assign fill_bytes  = in_byte_cnt - out_byte_cnt;
  assign fill_frames = in_frame_cnt - out_frame_cnt;
endmodule

// File: rtl/hdlc_frame_fifo_chk.sv
module hdlc_frame_fifo_chk #(
  parameter int ADDR_W = 8,
  parameter int FRM_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rd_valid,
  input logic              rd_eof,
  input logic [ADDR_W-1:0] in_byte_cnt,
  input logic [ADDR_W-1:0] out_byte_cnt,
  input logic [FRM_W-1:0]  out_frame_cnt,
  input logic [FRM_W-1:0]  in_frame_cnt,
  input logic [ADDR_W-1:0] fill_bytes,
  input logic [FRM_W-1:0]  fill_frames,
  input logic              ovf_flag,
  input logic              frame_open
);
  localparam logic [ADDR_W-1:0] BCAP = {ADDR_W{1'b1}};
  localparam logic [FRM_W-1:0]  FCAP = {FRM_W{1'b1}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (in_byte_cnt == '0 && out_byte_cnt == '0 && in_frame_cnt == '0 &&
             out_frame_cnt == '0 && !ovf_flag && !rd_valid));

  assert_full_refuse_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fill_bytes == BCAP) |=> (in_byte_cnt == $past(in_byte_cnt) &&
                                       in_frame_cnt == $past(in_frame_cnt) && ovf_flag));

  assert_frame_cap_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !frame_open && fill_frames == FCAP) |=>
      (in_byte_cnt == $past(in_byte_cnt) && ovf_flag));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  assert_read_step_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fill_bytes != '0) |=>
      (rd_valid && out_byte_cnt == ADDR_W'($past(out_byte_cnt) + 1'b1)));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fill_bytes == '0) |=> (!rd_valid && $stable(out_byte_cnt)));

  assert_frame_out_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_eof) |=> (out_frame_cnt == FRM_W'($past(out_frame_cnt) + 1'b1)));
endmodule

bind hdlc_frame_fifo hdlc_frame_fifo_chk #(.ADDR_W(ADDR_W), .FRM_W(FRM_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .rd_en         (rd_en),
  .rd_valid      (rd_valid),
  .rd_eof        (rd_eof),
  .in_byte_cnt   (in_byte_cnt),
  .out_byte_cnt  (out_byte_cnt),
  .out_frame_cnt (out_frame_cnt),
  .in_frame_cnt  (in_frame_cnt),
  .fill_bytes    (fill_bytes),
  .fill_frames   (fill_frames),
  .ovf_flag      (ovf_flag),
  .frame_open    (frame_open)
);

// File: tb/hdlc_frame_fifo_bench.sv
`timescale 1ns/1ps
module hdlc_frame_fifo_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_eof = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_valid, rd_eof, ovf_flag;
  logic [7:0] rd_data, in_byte_cnt, out_byte_cnt, fill_bytes;
  logic [2:0] in_frame_cnt, out_frame_cnt, fill_frames;

  always #2 clk = ~clk;

  hdlc_frame_fifo u_hdlc_frame_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eof(rd_eof),
    .in_byte_cnt(in_byte_cnt), .out_byte_cnt(out_byte_cnt),
    .in_frame_cnt(in_frame_cnt), .out_frame_cnt(out_frame_cnt),
    .fill_bytes(fill_bytes), .fill_frames(fill_frames), .ovf_flag(ovf_flag)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // bench model
  logic [7:0] m_data [256];
  logic       m_eof  [256];
  logic [7:0] m_z1, m_z2;
  logic [2:0] m_f1, m_f2;
  logic       m_open, m_ovf, m_pend, e_valid, e_eof;
  logic [7:0] e_data;

  task automatic chk(input string rq, input string scen, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d", rq, scen, what, act, exp);
    end
  endtask

  task automatic compare_all(input string scen);
    chk("R2", scen, "in_byte_cnt", in_byte_cnt, m_z1);
    chk("R2", scen, "in_frame_cnt", in_frame_cnt, m_f1);
    chk("R6", scen, "out_byte_cnt", out_byte_cnt, m_z2);
    chk("R8", scen, "out_frame_cnt", out_frame_cnt, m_f2);
    chk("R9", scen, "fill_bytes", fill_bytes, 8'(m_z1 - m_z2));
    chk("R9", scen, "fill_frames", fill_frames, 3'(m_f1 - m_f2));
    chk("R5", scen, "ovf_flag", ovf_flag, m_ovf);
    chk("R6", scen, "rd_valid", rd_valid, e_valid);
    if (e_valid) begin
      chk("R6", scen, "rd_data", rd_data, e_data);
      chk("R6", scen, "rd_eof", rd_eof, e_eof);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_z1 = 0; m_z2 = 0; m_f1 = 0; m_f2 = 0;
    m_open = 0; m_ovf = 0; m_pend = 0; e_valid = 0; e_eof = 0; e_data = 0;
    compare_all("R1");
  endtask

  // one clock: drive at falling edge, check at the next falling edge
  task automatic step(input logic we, input logic [7:0] wd, input logic weof,
                      input logic re, input string scen);
    logic acc, rok;
    logic [7:0] fb;
    logic [2:0] ff;
    wr_en = we; wr_data = wd; wr_eof = weof; rd_en = re;
    fb  = m_z1 - m_z2;
    ff  = m_f1 - m_f2;
    acc = we && (fb != 8'hFF) && (m_open || ff != 3'd7);
    rok = re && (fb != 8'h00);
    @(posedge clk);
    if (m_pend) m_f2 = m_f2 + 3'd1;
    m_pend = 1'b0;
    if (rok) begin
      e_data = m_data[m_z2];
      e_eof  = m_eof[m_z2];
      m_z2   = m_z2 + 8'd1;
      m_pend = e_eof;
    end
    e_valid = rok;
    if (acc) begin
      m_data[m_z1] = wd;
      m_eof[m_z1]  = weof;
      m_z1   = m_z1 + 8'd1;
      if (weof) m_f1 = m_f1 + 3'd1;
      m_open = !weof;
    end
    if (we && !acc) m_ovf = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    compare_all(scen);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // empty reads are ignored
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R7");

    // sweep of frame lengths, write then read back
    for (int len = 1; len <= 12; len++) begin
      for (int i = 0; i < len; i++)
        step(1'b1, 8'(len * 17 + i * 3), (i == len - 1), 1'b0, "R2");
      for (int i = 0; i < len; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R6");
      step(1'b0, 8'h00, 1'b0, 1'b0, "R8");
    end

    // reading an open frame
    for (int i = 0; i < 5; i++) step(1'b1, 8'(8'hA0 + i), 1'b0, 1'b1, "R11");
    step(1'b1, 8'hAF, 1'b1, 1'b1, "R11");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R11");

    // closing write and closing read in the same cycle
    for (int len = 1; len <= 4; len++) begin
      for (int i = 0; i < len; i++)
        step(1'b1, 8'(8'h40 + len * 8 + i), (i == len - 1), 1'b0, "R10");
      for (int i = 0; i < len; i++)
        step(1'b1, 8'(8'h80 + len * 8 + i), (i == len - 1), 1'b1, "R10");
      for (int i = 0; i < len + 2; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R10");
    end

    // frame cap of seven
    do_reset();
    for (int f = 0; f < 7; f++) begin
      step(1'b1, 8'(f * 2), 1'b0, 1'b0, "R4");
      step(1'b1, 8'(f * 2 + 1), 1'b1, 1'b0, "R4");
    end
    step(1'b1, 8'hEE, 1'b0, 1'b0, "R4");
    step(1'b1, 8'hEF, 1'b1, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R4");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R4");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R8");
    step(1'b1, 8'h55, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h56, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 18; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R6");

    // byte capacity
    do_reset();
    for (int i = 0; i < 255; i++) step(1'b1, 8'(i * 7 + 1), 1'b0, 1'b0, "R2");
    step(1'b1, 8'h99, 1'b0, 1'b0, "R3");
    step(1'b1, 8'h9A, 1'b1, 1'b0, "R3");
    step(1'b1, 8'h9B, 1'b0, 1'b1, "R10");
    step(1'b1, 8'h9C, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 260; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R7");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R5");

    do_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule